// File: doc/BRIEF.md
# Clear-on-read event interrupt controller

This block turns single-cycle event strobes from three sources (watchdog expiry, alarm match and supply-fail detect) into sticky flags and an interrupt line for a host processor. Each flag stays set until the host reads the flag register over a simple register bus. That read returns the pending causes and clears them all in the same cycle. A control register holds one enable per source, a polarity bit and a mode bit. The polarity bit selects an active-high push-pull output or an active-low open-drain output. The mode bit selects a level interrupt, which holds until the flags are read, or a fixed-length pulse meant to reset the host. The pulse length is derived from the clock frequency and a duration in milliseconds.

The block is told when the system runs from the backup supply and when the power-up restore has completed. Outside normal operation, strobes are dropped and the line is held inactive. In push-pull mode the line may only be driven high while the supply is above the switchover threshold (`vcc_ok`). The open-drain line is modelled as a data bit that is always 0 plus an output enable.

The output sequencer has four states:
- `PIN_IDLE`: no drive.
- `PIN_LEVEL`: level drive.
- `PIN_PULSE`: timed drive.
- `PIN_SPENT`: the pulse has expired but flags are still pending.

Its transitions are:
- `PIN_IDLE`→`PIN_LEVEL` or `PIN_PULSE` on a request, chosen by the mode bit.
- `PIN_PULSE`→`PIN_SPENT` when the counter reaches its last cycle.
- `PIN_LEVEL`, `PIN_PULSE` or `PIN_SPENT`→`PIN_IDLE` when the request drops.
- Any state→`PIN_IDLE` on a flag read or when not in normal operation.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all flags are 0 and the control register is 0, so the line is open-drain and released (`irq_oe`=0). Reads of both registers return 0.
- R2: A strobe in the cycle before an edge sets its flag at that edge. The flag bits are 0 for the watchdog, 1 for the alarm and 2 for supply-fail, read at address 0x7FF0. If the matching enable bit is set, the interrupt becomes active one edge later. With the enable at 0, the flag still sets and the line stays inactive.
- R3: The control register sits at address 0x7FF6 and reads back the last byte written. Bits 2:0 are the enables in the same order as the flags. Bit 3 is polarity: 1 gives push-pull with `irq_oe`=1 and `irq_o` equal to the active state. 0 gives open-drain with `irq_o`=0 and `irq_oe` equal to the active state.
- R4: In push-pull mode `irq_o` is 0 whenever `vcc_ok` is 0.
- R5: With bit 4 at 1, the interrupt is active for exactly PULSE_CYCLES = (CLK_HZ/1000)*PULSE_MS cycles. After that the line stays inactive while flags remain set. A further event during the pulse neither restarts nor extends it.
- R6: With bit 4 at 0, the interrupt stays active until the flags are read. A flag read returns the flags, clears all of them, and makes the line inactive at the same edge, even in the middle of a pulse.
- R7: A strobe in the same cycle as a flag read leaves its flag set after the clear. The read returns the flags as they were before that strobe.
- R8: While `on_backup` is 1 or `recall_done` is 0, strobes set no flag and the line is inactive.
- R9: Read data is registered and appears the cycle after the read; it is 0 otherwise. Unmapped addresses read 0. A write to the flag address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_wdog | input | 1 | Watchdog expiry strobe |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_pfail | input | 1 | Supply-fail strobe |
| on_backup | input | 1 | System is running from backup supply |
| recall_done | input | 1 | Power-up restore has finished |
| vcc_ok | input | 1 | Supply is above the switchover threshold |
| irq_o | output | 1 | Interrupt data bit |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
A strobe shows in the flag register at the next edge and on the line one edge after that. A flag read clears the flags, drops the line and loads `bus_rdata` all at the same edge. A pulse holds the line for exactly PULSE_CYCLES falling-edge samples.

The bench keeps a behavioural model that advances on the same rising edges as the design. It compares the resolved line, `irq_oe` and `bus_rdata` 2 ns after every rising edge, when inputs driven on the falling edge have long settled. The directed checks sample on falling edges counted from each stimulus: one edge after a strobe for the flag, and two edges after it for the line.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int unsigned NSRC   = 3;
    localparam int unsigned CTRL_W = NSRC + 2;

    localparam int unsigned SRC_WDOG  = 0;
    localparam int unsigned SRC_ALARM = 1;
    localparam int unsigned SRC_PFAIL = 2;

    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_LEVEL,
        PIN_PULSE,
        PIN_SPENT
    } pin_state_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_FLAG_RD,
        ACC_CTRL_RD,
        ACC_CTRL_WR,
        ACC_OTHER
    } acc_e;

    typedef struct packed {
        logic            pulse_mode;
        logic            act_high;
        logic [NSRC-1:0] en;
    } irq_ctrl_t;

endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
    import irqf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  logic [NSRC-1:0] stb,
    input  logic            rd_clr,
    output logic [NSRC-1:0] flags_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic bit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (armed && stb[i]) begin
                bit_q <= 1'b1;
            end else if (rd_clr) begin
                bit_q <= 1'b0;
            end
        end

        assign flags_o[i] = bit_q;
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && stb == '0) |=> (flags_o == '0)) else $error("flags survived read"); // R6

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stb != '0) |=> ((flags_o & $past(stb)) == $past(stb))) else $error("event lost"); // R7

    AST_UNARMED_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> ((flags_o & ~$past(flags_o)) == '0)) else $error("flag set when unarmed"); // R8

endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
    import irqf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 15'h7FF0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7FF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   flags,
    output logic              rd_clr,
    output irq_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - NSRC;

    acc_e              acc;
    logic [DATA_W-1:0] ctrl_q;

    always_comb begin
        if (!sel) begin
            acc = ACC_NONE;
        end else if (addr == FLAG_ADDR && !wr) begin
            acc = ACC_FLAG_RD;
        end else if (addr == CTRL_ADDR) begin
            acc = wr ? ACC_CTRL_WR : ACC_CTRL_RD;
        end else begin
            acc = ACC_OTHER;
        end
    end

    assign rd_clr = (acc == ACC_FLAG_RD);
    assign ctrl_o = irq_ctrl_t'(ctrl_q[CTRL_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rdata  <= '0;
        end else begin
            rdata <= '0;
            unique case (acc)
                ACC_FLAG_RD: rdata  <= {{PAD_W{1'b0}}, flags};
                ACC_CTRL_RD: rdata  <= ctrl_q;
                ACC_CTRL_WR: ctrl_q <= wdata;
                ACC_NONE, ACC_OTHER: ;
                default: ;
            endcase
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && addr == CTRL_ADDR) |=> $stable(ctrl_o)) else $error("ctrl changed"); // R3

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (rdata == '0)) else $error("rdata not zero"); // R9

endmodule

// File: rtl/irqf_pin_seq.sv
module irqf_pin_seq
    import irqf_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic req,
    input  logic rd_clr,
    input  logic pulse_mode,
    input  logic act_high,
    input  logic vcc_ok,
    output logic irq_o,
    output logic irq_oe
);

    localparam int unsigned CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    pin_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             drive_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PIN_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (!armed || rd_clr) begin
            state_nxt = PIN_IDLE;
        end else begin
            unique case (state)
                PIN_IDLE:  if (req) state_nxt = pulse_mode ? PIN_PULSE : PIN_LEVEL;
                PIN_LEVEL: if (!req) state_nxt = PIN_IDLE;
                PIN_PULSE: begin
                    if (!req) begin
                        state_nxt = PIN_IDLE;
                    end else if (cnt == LAST) begin
                        state_nxt = PIN_SPENT;
                    end
                end
                PIN_SPENT: if (!req) state_nxt = PIN_IDLE;
                default:   state_nxt = PIN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == PIN_PULSE && state_nxt == PIN_PULSE) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        drive_act = (state == PIN_LEVEL) || (state == PIN_PULSE);
        if (act_high) begin
            irq_o  = drive_act && vcc_ok;
            irq_oe = 1'b1;
        end else begin
            irq_o  = 1'b0;
            irq_oe = drive_act;
        end
    end

    AST_NO_REQ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_IDLE && !req) |=> !drive_act) else $error("drive without request"); // R2

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !act_high |-> !irq_o) else $error("open-drain drove high"); // R3

    AST_PP_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_high && !vcc_ok) |-> !irq_o) else $error("high without supply"); // R4

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST) else $error("pulse counter overran"); // R5

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PIN_SPENT && req && armed && !rd_clr) |=> !drive_act) else $error("pulse retriggered"); // R5

    AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !drive_act) else $error("read did not drop line"); // R6

    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !drive_act) else $error("drive while unarmed"); // R8

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import irqf_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned PULSE_MS  = 200,
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 15'h7FF0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7FF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_wdog,
    input  logic              evt_alarm,
    input  logic              evt_pfail,
    input  logic              on_backup,
    input  logic              recall_done,
    input  logic              vcc_ok,
    output logic              irq_o,
    output logic              irq_oe
);

    localparam int unsigned PULSE_CYCLES = (CLK_HZ / 1000) * PULSE_MS;

    logic            armed;
    logic [NSRC-1:0] stb;
    logic [NSRC-1:0] flags;
    logic            rd_clr;
    logic            req;
    irq_ctrl_t       ctrl;

    assign armed            = recall_done && !on_backup;
    assign stb[SRC_WDOG]    = evt_wdog;
    assign stb[SRC_ALARM]   = evt_alarm;
    assign stb[SRC_PFAIL]   = evt_pfail;
    assign req              = |(flags & ctrl.en);

    irqf_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed),
        .stb     (stb),
        .rd_clr  (rd_clr),
        .flags_o (flags)
    );

    irqf_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLAG_ADDR (FLAG_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .flags  (flags),
        .rd_clr (rd_clr),
        .ctrl_o (ctrl),
        .rdata  (bus_rdata)
    );

    irqf_pin_seq #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .req        (req),
        .rd_clr     (rd_clr),
        .pulse_mode (ctrl.pulse_mode),
        .act_high   (ctrl.act_high),
        .vcc_ok     (vcc_ok),
        .irq_o      (irq_o),
        .irq_oe     (irq_oe)
    );

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl.en) == '0 && ctrl.en == '0 && !ctrl.act_high) |-> !irq_oe) else $error("masked source drove line"); // R2

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

    localparam int CLK_HZ = 10_000;
    localparam int PMS    = 200;
    localparam int N      = (CLK_HZ / 1000) * PMS;
    localparam logic [14:0] FA = 15'h7FF0;
    localparam logic [14:0] CA = 15'h7FF6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        evt_wdog = 1'b0, evt_alarm = 1'b0, evt_pfail = 1'b0;
    logic        on_backup = 1'b0, recall_done = 1'b0, vcc_ok = 1'b1;
    logic        irq_o, irq_oe, line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    assign line = irq_oe ? irq_o : 1'b1;

    evt_irq_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_MS(PMS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_wdog(evt_wdog), .evt_alarm(evt_alarm), .evt_pfail(evt_pfail),
        .on_backup(on_backup), .recall_done(recall_done), .vcc_ok(vcc_ok),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model: 0 idle, 1 level, 2 pulse, 3 spent
    logic [2:0] m_flags = '0;
    logic [7:0] m_ctrl  = '0;
    logic [7:0] m_rdata = '0;
    int         m_state = 0;
    int         m_cnt   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; m_ctrl = '0; m_rdata = '0; m_state = 0; m_cnt = 0;
        end else begin
            automatic bit armed = recall_done && !on_backup;
            automatic bit rdf   = bus_sel && !bus_wr && bus_addr == FA;
            automatic bit rdc   = bus_sel && !bus_wr && bus_addr == CA;
            automatic bit wrc   = bus_sel && bus_wr && bus_addr == CA;
            automatic bit req   = (m_flags & m_ctrl[2:0]) != 0;
            automatic logic [2:0] ev = {evt_pfail, evt_alarm, evt_wdog} & {3{armed}};
            m_rdata = rdf ? {5'b0, m_flags} : (rdc ? m_ctrl : 8'h00);
            if (!armed || rdf) begin
                m_state = 0; m_cnt = 0;
            end else if (m_state == 0) begin
                if (req) begin m_state = m_ctrl[4] ? 2 : 1; m_cnt = 0; end
            end else if (!req) begin
                m_state = 0; m_cnt = 0;
            end else if (m_state == 2) begin
                if (m_cnt == N - 1) begin m_state = 3; m_cnt = 0; end
                else m_cnt++;
            end
            m_flags = (rdf ? 3'b000 : m_flags) | ev;
            if (wrc) m_ctrl = bus_wdata;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            automatic bit act = (m_state == 1) || (m_state == 2);
            automatic bit eline = m_ctrl[3] ? (act && vcc_ok) : !act;
            automatic bit eoe   = m_ctrl[3] ? 1'b1 : act;
            check_eq("R2/R3/R4/R5/R6/R8 line vs model", int'(line), int'(eline));
            check_eq("R3 oe vs model", int'(irq_oe), int'(eoe));
            check_eq("R9 rdata vs model", int'(bus_rdata), int'(m_rdata));
        end
    end

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [14:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fire(input int idx);
        evt_wdog  = (idx == 0);
        evt_alarm = (idx == 1);
        evt_pfail = (idx == 2);
        @(negedge clk);
        evt_wdog = 1'b0; evt_alarm = 1'b0; evt_pfail = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 line released", int'(line), 1);
        check_eq("R1 oe low", int'(irq_oe), 0);
        do_read(FA, d); check_eq("R1 flags zero", int'(d), 0);
        do_read(CA, d); check_eq("R1 ctrl zero", int'(d), 0);

        recall_done = 1'b1;
        @(negedge clk);

        // R2 disabled source still flags
        fire(1);
        repeat (3) @(negedge clk);
        check_eq("R2 masked line idle", int'(line), 1);
        do_read(FA, d); check_eq("R2 alarm flag bit1", int'(d), 8'h02);
        do_read(FA, d); check_eq("R6 flags cleared", int'(d), 0);

        // R3 control readback, push-pull level
        do_write(CA, 8'h0F);
        do_read(CA, d); check_eq("R3 ctrl readback", int'(d), 8'h0F);
        fire(0);
        check_eq("R2 not yet active", int'(line), 0);
        @(negedge clk);
        check_eq("R2 active two edges after strobe", int'(line), 1);
        repeat (20) @(negedge clk);
        check_eq("R6 level holds", int'(line), 1);

        // R4 supply gating
        vcc_ok = 1'b0;
        @(negedge clk);
        check_eq("R4 no high without supply", int'(irq_o), 0);
        check_eq("R4 push-pull oe", int'(irq_oe), 1);
        vcc_ok = 1'b1;
        @(negedge clk);
        check_eq("R4 restored", int'(line), 1);
        do_read(FA, d); check_eq("R6 read returns wdog", int'(d), 8'h01);
        check_eq("R6 line drops at read", int'(line), 0);

        // R3 open-drain active low
        do_write(CA, 8'h07);
        check_eq("R3 od released", int'(irq_oe), 0);
        fire(2);
        @(negedge clk);
        check_eq("R3 od drives", int'(irq_oe), 1);
        check_eq("R3 od low", int'(line), 0);
        do_read(FA, d); check_eq("R2 pfail flag bit2", int'(d), 8'h04);
        check_eq("R6 od released after read", int'(irq_oe), 0);

        // R5 pulse length, no retrigger
        do_write(CA, 8'h1F);
        fire(1);
        cnt = 0;
        for (int i = 0; i < N + 40; i++) begin
            @(negedge clk);
            if (line) cnt++;
            evt_alarm = (i == 500) || (i == N + 5);
        end
        evt_alarm = 1'b0;
        check_eq("R5 pulse length", cnt, N);
        check_eq("R5 spent stays idle", int'(line), 0);
        do_read(FA, d); check_eq("R5 flag still pending", int'(d), 8'h02);

        // R6 early end of pulse
        fire(0);
        repeat (100) @(negedge clk);
        check_eq("R6 pulse running", int'(line), 1);
        do_read(FA, d); check_eq("R6 wdog flag", int'(d), 8'h01);
        check_eq("R6 pulse cut", int'(line), 0);
        @(negedge clk);
        check_eq("R6 stays idle", int'(line), 0);

        // R7 strobe during read
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = FA; evt_pfail = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; evt_pfail = 1'b0;
        check_eq("R7 read sees old flags", int'(bus_rdata), 0);
        do_read(FA, d); check_eq("R7 flag kept", int'(d), 8'h04);

        // R8 backup and before recall
        on_backup = 1'b1;
        fire(0);
        check_eq("R8 line idle on backup", int'(line), 0);
        do_read(FA, d); check_eq("R8 no flag on backup", int'(d), 0);
        on_backup = 1'b0;
        do_write(CA, 8'h0F);
        fire(0);
        @(negedge clk);
        check_eq("R8 active before backup", int'(line), 1);
        on_backup = 1'b1;
        @(negedge clk);
        check_eq("R8 gated by backup", int'(line), 0);
        on_backup = 1'b0;
        do_read(FA, d); check_eq("R8 flag from before backup", int'(d), 8'h01);
        recall_done = 1'b0;
        fire(1);
        do_read(FA, d); check_eq("R8 no flag before recall", int'(d), 0);
        recall_done = 1'b1;

        // R9 bus corner cases
        do_write(FA, 8'h07);
        do_read(FA, d); check_eq("R9 flag write ignored", int'(d), 0);
        do_read(15'h1234, d); check_eq("R9 unmapped reads zero", int'(d), 0);
        @(negedge clk);
        check_eq("R9 idle rdata zero", int'(bus_rdata), 0);
        do_read(CA, d); check_eq("R9 ctrl intact", int'(d), 8'h0F);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule